// File: doc/BRIEF.md
# Threshold-Signalled Byte FIFO Pair

This block sits between a register-side host and a serial shifter. It holds one byte queue toward the shifter (transmit) and one byte queue from the shifter (receive). Each direction has its own 2-bit threshold code, and that code sets when the corresponding ready output asserts. The ready outputs are meant to drive DMA or interrupt requests. A code can require one, two or four slots to be free on the transmit side, or one, two or four bytes to be waiting on the receive side.

The queues can be switched off. When switched off, each direction behaves as a single holding register, so software that moves one byte at a time sees the same behaviour in both modes. Flush commands empty either queue or both. A soft reset returns the block to its power-up state, which has the queues switched off. The enable command is issued after the soft reset.

A lock input, typically raised by the protocol engine after a refused byte, freezes the transmit queue toward the shifter. The lock stays set after the input drops. It is released by an unlock command, and that command can be combined with a transmit flush to discard stale bytes in the same cycle.

Top module: `fifo_pair`

## Requirements
- R1: After reset both levels are 0, `tx_ready`=1, `rx_ready`=0, `fifo_enabled`=0, `tx_locked`=0, `tx_out_valid`=0, `host_rdata`=0 and all four error pulses are 0.
- R2: A cycle with `cfg_we`=1 stores `cfg_tx_thr` and `cfg_rx_thr`. The code values are 0 for one, 1 for two and 2 for four, and code 3 behaves as one. The stored codes take effect only while the queues are enabled.
- R3: While enabled, `tx_ready` is 1 exactly when DEPTH minus `tx_level` is at least the transmit threshold count.
- R4: While enabled, `rx_ready` is 1 exactly when `rx_level` is at least the receive threshold count.
- R5: While disabled, each direction holds at most one byte, `tx_ready` equals (`tx_level`==0), `rx_ready` equals (`rx_level`==1), and the threshold codes have no effect.
- R6: Bytes leave each queue in arrival order. `tx_out_data` shows the transmit head whenever `tx_out_valid` is 1. A `host_rd` of a non-empty receive queue places the head byte on `host_rdata` one cycle later, and `host_rdata` holds that value until the next successful read.
- R7: A push into a full queue is dropped, the level is unchanged, and the overflow pulse (`tx_ovf` for `host_wr`, `rx_ovf` for `rx_in_push`) is 1 for one cycle. A push in the same cycle as an accepted pop is not a push into a full queue.
- R8: A pop of an empty queue leaves the level and `host_rdata` unchanged and raises the underflow pulse (`rx_unf` for `host_rd`, `tx_unf` for an unlocked `tx_out_take`) for one cycle.
- R9: `cmd_tx_flush` empties the transmit queue and `cmd_rx_flush` empties the receive queue. Both can be given in one cycle. Data operations on a flushed side in that cycle are ignored and raise no pulse, and the other side is unaffected.
- R10: `lock_in`=1 sets `tx_locked`, which stays set. While locked, `tx_out_valid`=0, `tx_out_take` is ignored without an underflow pulse, queued bytes are kept, and host writes are still accepted.
- R11: `cmd_unlock` with `lock_in`=0 clears `tx_locked`, and with `lock_in`=1 it has no effect. Together with `cmd_tx_flush` it releases the lock and empties the transmit queue in the same cycle.
- R12: `cmd_fifo_on` sets and `cmd_fifo_off` clears `fifo_enabled`, and `cmd_fifo_off` wins if both are given. Either command empties both queues, and data operations in that cycle are ignored.
- R13: `cmd_srst` has priority over every other input in its cycle and restores the R1 state, including threshold codes 0 and the disabled mode. An enable command in the next cycle takes effect.
- R14: `tx_level` and `rx_level` report occupancy. An accepted push together with an accepted pop leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Store threshold codes |
| cfg_tx_thr | input | 2 | Transmit threshold code |
| cfg_rx_thr | input | 2 | Receive threshold code |
| cmd_srst | input | 1 | Soft reset |
| cmd_fifo_on | input | 1 | Enable queue mode |
| cmd_fifo_off | input | 1 | Disable queue mode |
| cmd_tx_flush | input | 1 | Empty transmit queue |
| cmd_rx_flush | input | 1 | Empty receive queue |
| cmd_unlock | input | 1 | Release transmit lock |
| host_wr | input | 1 | Host pushes a byte to transmit |
| host_wdata | input | 8 | Host byte to transmit |
| host_rd | input | 1 | Host pops a received byte |
| host_rdata | output | 8 | Last byte popped by host |
| tx_out_valid | output | 1 | Transmit head available to shifter |
| tx_out_data | output | 8 | Transmit head byte |
| tx_out_take | input | 1 | Shifter consumes transmit head |
| rx_in_push | input | 1 | Shifter delivers a byte |
| rx_in_data | input | 8 | Byte from shifter |
| lock_in | input | 1 | Sets the transmit lock |
| tx_locked | output | 1 | Transmit lock state |
| tx_ready | output | 1 | Transmit threshold met |
| rx_ready | output | 1 | Receive threshold met |
| tx_level | output | $clog2(DEPTH+1) | Transmit occupancy |
| rx_level | output | $clog2(DEPTH+1) | Receive occupancy |
| fifo_enabled | output | 1 | Queue mode active |
| tx_ovf | output | 1 | Transmit push dropped |
| tx_unf | output | 1 | Transmit pop of empty queue |
| rx_ovf | output | 1 | Receive push dropped |
| rx_unf | output | 1 | Receive pop of empty queue |

## Verification
Every result of a stimulus is due right after the single clock edge that samples it. Levels, the ready outputs, `tx_out_valid`/`tx_out_data`, `host_rdata`, the lock and enable state, and the four error pulses all come from state registered on that edge, and no input reaches any output without passing through a register. The bench therefore drives inputs on the falling edge, lets exactly one rising edge pass, and compares on the next falling edge. The error pulses are checked in that cycle and checked to be clear one cycle later. Threshold behaviour is swept over every code and every occupancy from empty to full on both sides.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

    typedef enum logic [1:0] {
        THR_ONE  = 2'd0,
        THR_TWO  = 2'd1,
        THR_FOUR = 2'd2,
        THR_RSVD = 2'd3
    } thr_mode_e;

    typedef struct packed {
        logic      fifo_en;
        thr_mode_e tx_mode;
        thr_mode_e rx_mode;
        logic      locked;
        logic [7:0] rdata;
        logic      tx_ovf;
        logic      tx_unf;
        logic      rx_ovf;
        logic      rx_unf;
    } ctl_t;

endpackage

// File: rtl/byte_ring.sv
module byte_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cap_one,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          push_ok,
    output logic          pop_ok
);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [LW-1:0] cnt;
    } ring_t;

    ring_t         cur_q, nxt_d;
    logic [W-1:0]  mem_q [DEPTH];
    logic [LW-1:0] cap;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        cap     = cap_one ? LW'(1) : LW'(DEPTH);
        pop_ok  = pop && !clr && (cur_q.cnt != '0);
        push_ok = push && !clr && ((cur_q.cnt < cap) || pop_ok);
        nxt_d   = cur_q;
        if (clr) begin
            nxt_d.wp  = '0;
            nxt_d.rp  = '0;
            nxt_d.cnt = '0;
        end else begin
            if (push_ok) nxt_d.wp = bump(cur_q.wp);
            if (pop_ok)  nxt_d.rp = bump(cur_q.rp);
            nxt_d.cnt = cur_q.cnt + LW'(push_ok) - LW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[cur_q.wp] <= wdata;
    end

    assign head  = mem_q[cur_q.rp];
    assign level = cur_q.cnt;

    // R14: occupancy never exceeds the capacity of the current mode
    assert_level_bound_R14: assert property (@(posedge clk) disable iff (!rst_n)
        level <= cap);

    // R9: a clear leaves the queue empty
    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> level == '0);

    // R7: a push into a full queue without a pop leaves the level alone
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && level == cap) |=> level == $past(level));

    // R14: a lone accepted push raises the level by one
    assert_push_count_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && level < cap) |=> level == $past(level) + LW'(1));

endmodule

// File: rtl/ready_gate.sv
module ready_gate
    import fifo_pair_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter bit IS_TX = 1'b1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  thr_mode_e     mode,
    input  logic          fifo_on,
    input  logic [LW-1:0] level,
    output logic          ready
);

    logic [LW-1:0] need;

    always_comb begin
        case (mode)
            THR_TWO:  need = LW'(2);
            THR_FOUR: need = LW'(4);
            default:  need = LW'(1);
        endcase
    end

    generate
        if (IS_TX) begin : g_tx
            logic [LW-1:0] room;
            always_comb begin
                room  = LW'(DEPTH) - level;
                ready = fifo_on ? (room >= need) : (level == '0);
            end
        end else begin : g_rx
            always_comb begin
                ready = fifo_on ? (level >= need) : (level != '0);
            end
        end
    endgenerate

endmodule

// File: rtl/fifo_pair.sv
module fifo_pair
    import fifo_pair_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_tx_thr,
    input  logic [1:0]    cfg_rx_thr,
    input  logic          cmd_srst,
    input  logic          cmd_fifo_on,
    input  logic          cmd_fifo_off,
    input  logic          cmd_tx_flush,
    input  logic          cmd_rx_flush,
    input  logic          cmd_unlock,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    input  logic          host_rd,
    output logic [7:0]    host_rdata,
    output logic          tx_out_valid,
    output logic [7:0]    tx_out_data,
    input  logic          tx_out_take,
    input  logic          rx_in_push,
    input  logic [7:0]    rx_in_data,
    input  logic          lock_in,
    output logic          tx_locked,
    output logic          tx_ready,
    output logic          rx_ready,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          fifo_enabled,
    output logic          tx_ovf,
    output logic          tx_unf,
    output logic          rx_ovf,
    output logic          rx_unf
);

    ctl_t ctl_q, ctl_d;

    logic       mode_clr, tx_clr, rx_clr, tx_pop_req;
    logic       tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [7:0] rx_head;

    always_comb begin
        mode_clr   = cmd_srst || cmd_fifo_on || cmd_fifo_off;
        tx_clr     = mode_clr || cmd_tx_flush;
        rx_clr     = mode_clr || cmd_rx_flush;
        tx_pop_req = tx_out_take && !ctl_q.locked;
    end

    byte_ring #(.DEPTH(DEPTH), .W(8)) u_tx_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_clr),
        .cap_one (!ctl_q.fifo_en),
        .push    (host_wr),
        .pop     (tx_pop_req),
        .wdata   (host_wdata),
        .head    (tx_out_data),
        .level   (tx_level),
        .push_ok (tx_push_ok),
        .pop_ok  (tx_pop_ok)
    );

    byte_ring #(.DEPTH(DEPTH), .W(8)) u_rx_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .cap_one (!ctl_q.fifo_en),
        .push    (rx_in_push),
        .pop     (host_rd),
        .wdata   (rx_in_data),
        .head    (rx_head),
        .level   (rx_level),
        .push_ok (rx_push_ok),
        .pop_ok  (rx_pop_ok)
    );

    ready_gate #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_gate (
        .mode    (ctl_q.tx_mode),
        .fifo_on (ctl_q.fifo_en),
        .level   (tx_level),
        .ready   (tx_ready)
    );

    ready_gate #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_gate (
        .mode    (ctl_q.rx_mode),
        .fifo_on (ctl_q.fifo_en),
        .level   (rx_level),
        .ready   (rx_ready)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.tx_ovf = 1'b0;
        ctl_d.tx_unf = 1'b0;
        ctl_d.rx_ovf = 1'b0;
        ctl_d.rx_unf = 1'b0;
        if (cmd_srst) begin
            ctl_d = '0;
        end else begin
            if (cmd_fifo_off)     ctl_d.fifo_en = 1'b0;
            else if (cmd_fifo_on) ctl_d.fifo_en = 1'b1;
            if (cfg_we) begin
                ctl_d.tx_mode = thr_mode_e'(cfg_tx_thr);
                ctl_d.rx_mode = thr_mode_e'(cfg_rx_thr);
            end
            if (lock_in)         ctl_d.locked = 1'b1;
            else if (cmd_unlock) ctl_d.locked = 1'b0;
            if (rx_pop_ok) ctl_d.rdata = rx_head;
            ctl_d.tx_ovf = host_wr    && !tx_clr && !tx_push_ok;
            ctl_d.tx_unf = tx_pop_req && !tx_clr && !tx_pop_ok;
            ctl_d.rx_ovf = rx_in_push && !rx_clr && !rx_push_ok;
            ctl_d.rx_unf = host_rd    && !rx_clr && !rx_pop_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign host_rdata   = ctl_q.rdata;
    assign tx_locked    = ctl_q.locked;
    assign fifo_enabled = ctl_q.fifo_en;
    assign tx_out_valid = (tx_level != '0) && !ctl_q.locked;
    assign tx_ovf       = ctl_q.tx_ovf;
    assign tx_unf       = ctl_q.tx_unf;
    assign rx_ovf       = ctl_q.rx_ovf;
    assign rx_unf       = ctl_q.rx_unf;

    // R13: soft reset restores the idle state one cycle later
    assert_srst_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_srst |=> (!fifo_enabled && !tx_locked && tx_level == '0
                      && rx_level == '0 && host_rdata == 8'h00));

    // R10: a locked queue without writes or clears keeps its occupancy
    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_locked && !lock_in && !cmd_unlock && !host_wr && !tx_clr)
        |=> (tx_level == $past(tx_level) && tx_locked));

    // R8: host_rdata only moves on a read or a soft reset
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd && !cmd_srst) |=> $stable(host_rdata));

    // R7: a write into a full enabled transmit queue without a take flags overflow
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !tx_out_take && !tx_clr && fifo_enabled
         && tx_level == LW'(DEPTH)) |=> tx_ovf);

endmodule

// File: tb/fifo_pair_tb.sv
module fifo_pair_tb;

    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cmd_srst = 0, cmd_fifo_on = 0, cmd_fifo_off = 0;
    logic cmd_tx_flush = 0, cmd_rx_flush = 0, cmd_unlock = 0;
    logic [1:0] cfg_tx_thr = 0, cfg_rx_thr = 0;
    logic host_wr = 0, host_rd = 0, tx_out_take = 0, rx_in_push = 0, lock_in = 0;
    logic [7:0] host_wdata = 0, rx_in_data = 0;
    logic [7:0] host_rdata, tx_out_data;
    logic tx_out_valid, tx_locked, tx_ready, rx_ready, fifo_enabled;
    logic tx_ovf, tx_unf, rx_ovf, rx_unf;
    logic [LW-1:0] tx_level, rx_level;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fifo_pair #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tx_thr(cfg_tx_thr),
        .cfg_rx_thr(cfg_rx_thr), .cmd_srst(cmd_srst), .cmd_fifo_on(cmd_fifo_on),
        .cmd_fifo_off(cmd_fifo_off), .cmd_tx_flush(cmd_tx_flush),
        .cmd_rx_flush(cmd_rx_flush), .cmd_unlock(cmd_unlock), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .tx_out_take(tx_out_take), .rx_in_push(rx_in_push), .rx_in_data(rx_in_data),
        .lock_in(lock_in), .tx_locked(tx_locked), .tx_ready(tx_ready),
        .rx_ready(rx_ready), .tx_level(tx_level), .rx_level(rx_level),
        .fifo_enabled(fifo_enabled), .tx_ovf(tx_ovf), .tx_unf(tx_unf),
        .rx_ovf(rx_ovf), .rx_unf(rx_unf)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        cfg_we = 0; cmd_srst = 0; cmd_fifo_on = 0; cmd_fifo_off = 0;
        cmd_tx_flush = 0; cmd_rx_flush = 0; cmd_unlock = 0;
        host_wr = 0; host_rd = 0; tx_out_take = 0; rx_in_push = 0; lock_in = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    function automatic int need(input int m);
        return (m == 1) ? 2 : (m == 2) ? 4 : 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_level", int'(tx_level), 0);
        chk("R1 rx_level", int'(rx_level), 0);
        chk("R1 tx_ready", int'(tx_ready), 1);
        chk("R1 rx_ready", int'(rx_ready), 0);
        chk("R1 fifo_enabled", int'(fifo_enabled), 0);
        chk("R1 tx_locked", int'(tx_locked), 0);
        chk("R1 tx_out_valid", int'(tx_out_valid), 0);
        chk("R1 host_rdata", int'(host_rdata), 0);
        chk("R1 pulses", int'({tx_ovf, tx_unf, rx_ovf, rx_unf}), 0);

        // R5 disabled: single holding register each way, thresholds ignored
        cfg_we = 1; cfg_tx_thr = 2; cfg_rx_thr = 2; tick();
        host_wr = 1; host_wdata = 8'hAA; rx_in_push = 1; rx_in_data = 8'h11; tick();
        chk("R5 tx_level", int'(tx_level), 1);
        chk("R5 tx_ready", int'(tx_ready), 0);
        chk("R5 rx_ready", int'(rx_ready), 1);
        chk("R6 tx_out_data", int'(tx_out_data), 8'hAA);
        chk("R6 tx_out_valid", int'(tx_out_valid), 1);
        host_wr = 1; host_wdata = 8'hBB; rx_in_push = 1; rx_in_data = 8'h22; tick();
        chk("R7 tx_ovf disabled", int'(tx_ovf), 1);
        chk("R7 rx_ovf disabled", int'(rx_ovf), 1);
        chk("R5 tx_level capped", int'(tx_level), 1);
        chk("R5 rx_level capped", int'(rx_level), 1);
        tx_out_take = 1; host_rd = 1; tick();
        chk("R7 pulse clears", int'(tx_ovf | rx_ovf), 0);
        chk("R6 host_rdata", int'(host_rdata), 8'h11);
        chk("R5 tx empty", int'(tx_level), 0);
        host_rd = 1; tx_out_take = 1; tick();
        chk("R8 rx_unf", int'(rx_unf), 1);
        chk("R8 tx_unf", int'(tx_unf), 1);
        chk("R8 rdata kept", int'(host_rdata), 8'h11);
        tick();
        chk("R8 pulse clears", int'(rx_unf | tx_unf), 0);

        // R12 enable
        cmd_fifo_on = 1; tick();
        chk("R12 enabled", int'(fifo_enabled), 1);

        // R2 R3 R4 sweep over every code and occupancy; R6 R7 R8 at the ends
        for (int m = 0; m < 4; m++) begin
            cfg_we = 1; cfg_tx_thr = 2'(m); cfg_rx_thr = 2'(m); tick();
            for (int k = 0; k <= DEPTH; k++) begin
                chk($sformatf("R3 tx_ready m%0d k%0d", m, k), int'(tx_ready),
                    int'((DEPTH - k) >= need(m)));
                chk($sformatf("R4 rx_ready m%0d k%0d", m, k), int'(rx_ready),
                    int'(k >= need(m)));
                chk("R14 levels", int'(tx_level) + 100 * int'(rx_level), k + 100 * k);
                host_wr = 1; host_wdata = 8'(m * 16 + k);
                rx_in_push = 1; rx_in_data = 8'(8'hF0 ^ (m * 16 + k));
                tick();
            end
            chk("R7 tx_ovf full", int'(tx_ovf), 1);
            chk("R7 rx_ovf full", int'(rx_ovf), 1);
            chk("R7 tx_level full", int'(tx_level), DEPTH);
            for (int k = 0; k < DEPTH; k++) begin
                chk("R6 tx order", int'(tx_out_data), (m * 16 + k) & 255);
                tx_out_take = 1; host_rd = 1; tick();
                chk("R6 rx order", int'(host_rdata), (8'hF0 ^ (m * 16 + k)) & 255);
            end
            host_rd = 1; tx_out_take = 1; tick();
            chk("R8 rx_unf enabled", int'(rx_unf), 1);
            chk("R8 tx_unf enabled", int'(tx_unf), 1);
            chk("R8 rdata held", int'(host_rdata), (8'hF0 ^ (m * 16 + DEPTH - 1)) & 255);
        end

        // R14 push and pop together on a full queue
        for (int k = 0; k < DEPTH; k++) begin host_wr = 1; host_wdata = 8'(k); tick(); end
        host_wr = 1; host_wdata = 8'h77; tx_out_take = 1; tick();
        chk("R14 level kept", int'(tx_level), DEPTH);
        chk("R7 no ovf with pop", int'(tx_ovf), 0);
        chk("R6 head advanced", int'(tx_out_data), 1);

        // R9 flushes
        for (int k = 0; k < 3; k++) begin rx_in_push = 1; rx_in_data = 8'(k); tick(); end
        cmd_tx_flush = 1; tick();
        chk("R9 tx flushed", int'(tx_level), 0);
        chk("R9 rx untouched", int'(rx_level), 3);
        cmd_tx_flush = 1; host_wr = 1; tick();
        chk("R9 push ignored", int'(tx_level), 0);
        chk("R9 no pulse", int'(tx_ovf), 0);
        host_wr = 1; tick();
        cmd_tx_flush = 1; cmd_rx_flush = 1; tick();
        chk("R9 both flushed", int'(tx_level) + int'(rx_level), 0);

        // R10 lock
        for (int k = 0; k < 3; k++) begin host_wr = 1; host_wdata = 8'(8'h40 + k); tick(); end
        lock_in = 1; tick();
        chk("R10 locked", int'(tx_locked), 1);
        chk("R10 valid low", int'(tx_out_valid), 0);
        tx_out_take = 1; tick();
        chk("R10 take ignored", int'(tx_level), 3);
        chk("R10 no unf", int'(tx_unf), 0);
        host_wr = 1; host_wdata = 8'h43; tick();
        chk("R10 write accepted", int'(tx_level), 4);
        lock_in = 1; cmd_unlock = 1; tick();
        chk("R11 unlock blocked", int'(tx_locked), 1);
        cmd_unlock = 1; tick();
        chk("R11 unlocked", int'(tx_locked), 0);
        chk("R11 valid back", int'(tx_out_valid), 1);
        chk("R10 contents kept", int'(tx_out_data), 8'h40);
        lock_in = 1; tick();
        cmd_unlock = 1; cmd_tx_flush = 1; tick();
        chk("R11 unlock+flush lock", int'(tx_locked), 0);
        chk("R11 unlock+flush level", int'(tx_level), 0);

        // R12 mode switching
        host_wr = 1; tick(); host_wr = 1; tick();
        cmd_fifo_off = 1; host_wr = 1; tick();
        chk("R12 disabled", int'(fifo_enabled), 0);
        chk("R12 emptied", int'(tx_level), 0);
        cmd_fifo_on = 1; tick();
        cmd_fifo_on = 1; cmd_fifo_off = 1; tick();
        chk("R12 off wins", int'(fifo_enabled), 0);

        // R13 soft reset
        cmd_fifo_on = 1; tick();
        cfg_we = 1; cfg_tx_thr = 2; cfg_rx_thr = 2; tick();
        rx_in_push = 1; rx_in_data = 8'h5A; lock_in = 1; host_wr = 1; tick();
        host_rd = 1; tick();
        cmd_srst = 1; host_wr = 1; rx_in_push = 1; cmd_fifo_on = 1; lock_in = 1; tick();
        chk("R13 disabled", int'(fifo_enabled), 0);
        chk("R13 unlocked", int'(tx_locked), 0);
        chk("R13 levels", int'(tx_level) + int'(rx_level), 0);
        chk("R13 rdata", int'(host_rdata), 0);
        cmd_fifo_on = 1; tick();
        chk("R13 enable after", int'(fifo_enabled), 1);
        rx_in_push = 1; tick();
        chk("R13 rx code reset", int'(rx_ready), 1);
        chk("R13 tx code reset", int'(tx_ready), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule